// File: doc/BRIEF.md
# Flash Line Buffer Accelerator

This block sits between a processor's memory port and a slow flash array that is read one 128-bit line at a time. It keeps three one-line holding buffers. The first holds prefetched instruction lines. The second holds the target line of the last instruction branch. The third holds the last data line read. A request that finds its line in a permitted buffer is answered from that buffer one cycle later. Any other request starts a flash line fetch, and the processor waits until the line arrives.

A two-bit mode input sets how much buffering is used. Mode 0 uses no buffering. Mode 1 answers only sequential instruction hits from the buffers. Modes 2 and 3 answer every hit. While the flash reports a program or erase operation, all buffers are cleared and the processor is held off. The first read after the operation therefore returns the new content from a fresh fetch.

Top module: `flash_line_accel`

## Requirements
- R1: A request address is split into a line tag (bits [18:4], 15 bits) and a word index (bits [3:2]). Each response carries word `index` (word 0 in bits [31:0] of the line) of the flash line named by the tag, in its current content.
- R2: In mode 0 every request, instruction or data, is answered only after a flash line fetch, and no prefetch fetch is issued.
- R3: In mode 1, a sequential instruction request whose line sits in the prefetch or branch buffer is answered with no fetch, with the ready pulse one cycle after the request is first sampled.
- R4: In mode 1, non-sequential instruction requests and all data requests are answered only after a flash line fetch, even when their line is buffered.
- R5: In modes 2 and 3, an instruction request that hits the prefetch or branch buffer, or a data request that hits the data buffer, is answered one cycle later with no fetch.
- R6: A data miss loads the whole four-word line into the data buffer, so the other words of that line later hit in mode 2.
- R7: In modes 1 to 3, an instruction miss fills the branch buffer, and line tag+1 is then fetched into the prefetch buffer. A served instruction hit on word 3 also queues a prefetch of the next line.
- R8: At most one line fetch is outstanding. Once raised, the fetch request stays high with a stable line address until it is acknowledged. A pending demand fetch is issued before a pending prefetch.
- R9: In any cycle after one in which the busy input is high, neither a response ready nor a fetch request is given.
- R10: Busy clears all three buffers. A read of a previously buffered line after busy ends fetches again and returns the post-operation content.
- R11: During and right after reset, the response ready and fetch request outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode | input | 2 | 0 none, 1 sequential instruction hits only, 2/3 all hits |
| req_valid | input | 1 | Request present; held until rsp_ready |
| req_addr | input | 32 | Byte address of the requested word |
| req_instr | input | 1 | 1 instruction fetch, 0 data read |
| req_seq | input | 1 | 1 sequential to the previous access |
| rsp_ready | output | 1 | One-cycle pulse: rsp_data valid, request done |
| rsp_data | output | 32 | Returned word |
| fl_req | output | 1 | Line fetch request, held until fl_ack |
| fl_line_addr | output | 15 | Line tag being fetched |
| fl_ack | input | 1 | One-cycle acknowledge with fl_line valid |
| fl_line | input | 128 | Fetched line, word 0 in the low bits |
| fl_busy | input | 1 | Flash program or erase in progress |

## Verification
The bench goes after hits that must not be served. Examples are a buffered data line or a branch in mode 1, and any buffered line in mode 0. A design that served them would return in one cycle with no fetch counted. It also checks that the next-line prefetch actually happens, because a missing prefetch turns the following sequential read into a slow miss. It raises busy in the middle of a request and changes the flash content. A design that kept its buffers would return the stale word, and one that ignored busy would answer or fetch during the operation. Random traffic over a few lines, under all modes, checks every returned word against the flash contents computed in the bench.

// File: rtl/fla_pkg.sv
package fla_pkg;
  typedef enum logic [1:0] {
    BUF_PF = 2'd0,
    BUF_BR = 2'd1,
    BUF_DT = 2'd2
  } buf_sel_e;

  localparam int NUM_BUFS = 3;
endpackage

// File: rtl/fla_line_buf.sv
// One holding buffer: a line tag, a valid flag and a line of words, with
// a tag comparator and a word select.
module fla_line_buf #(
  parameter int TAG_W  = 15,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  localparam int WIDX_W = $clog2(WORDS),
  localparam int LINE_W = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              inval,
  input  logic              fill_en,
  input  logic [TAG_W-1:0]  fill_tag,
  input  logic [LINE_W-1:0] fill_line,
  input  logic [TAG_W-1:0]  cmp_tag,
  input  logic [WIDX_W-1:0] widx,
  output logic              vld,
  output logic              hit,
  output logic [WORD_W-1:0] word
);
  logic                           vld_q;
  logic [TAG_W-1:0]               tag_q;
  logic [WORDS-1:0][WORD_W-1:0]   line_q;

  always_ff @(posedge clk) begin
    if (rst || inval) begin
      vld_q <= 1'b0;
      tag_q <= '0;
    end else if (fill_en) begin
      vld_q <= 1'b1;
      tag_q <= fill_tag;
    end
  end

  // Line storage carries no reset so it can map onto RAM-style registers.
  always_ff @(posedge clk) begin
    if (fill_en) line_q <= fill_line;
  end

  assign vld  = vld_q;
  assign hit  = vld_q && (tag_q == cmp_tag);
  assign word = line_q[widx];
endmodule

// File: rtl/fla_policy.sv
// Decides, per mode, whether a request may be answered from a buffer.
module fla_policy
  import fla_pkg::*;
(
  input  logic     [1:0] mode,
  input  logic           is_instr,
  input  logic           is_seq,
  input  logic           hit_pf,
  input  logic           hit_br,
  input  logic           hit_dt,
  output logic           use_buf,
  output buf_sel_e       src
);
  always_comb begin
    use_buf = 1'b0;
    src     = BUF_DT;
    if (is_instr) begin
      src = hit_pf ? BUF_PF : BUF_BR;
      if (hit_pf || hit_br)
        use_buf = mode[1] || ((mode == 2'b01) && is_seq);
    end else begin
      use_buf = hit_dt && mode[1];
    end
  end
endmodule

// File: rtl/flash_line_accel.sv
module flash_line_accel
  import fla_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int WORD_W = 32,
  parameter int WORDS  = 4,
  parameter int TAG_W  = 15,
  localparam int WIDX_W   = $clog2(WORDS),
  localparam int BYTE_LSB = $clog2(WORD_W / 8),
  localparam int TAG_LSB  = BYTE_LSB + WIDX_W,
  localparam int LINE_W   = WORD_W * WORDS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_instr,
  input  logic              req_seq,
  output logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_data,
  output logic              fl_req,
  output logic [TAG_W-1:0]  fl_line_addr,
  input  logic              fl_ack,
  input  logic [LINE_W-1:0] fl_line,
  input  logic              fl_busy
);
  localparam logic [WIDX_W-1:0] LAST_W = WIDX_W'(WORDS - 1);

  logic [TAG_W-1:0]  req_tag;
  logic [WIDX_W-1:0] req_widx;
  logic [ADDR_W-TAG_W-WIDX_W-1:0] unused_addr;
  assign req_tag     = req_addr[TAG_LSB +: TAG_W];
  assign req_widx    = req_addr[BYTE_LSB +: WIDX_W];
  assign unused_addr = {req_addr[ADDR_W-1:TAG_LSB+TAG_W], req_addr[BYTE_LSB-1:0]};

  logic [WORDS-1:0][WORD_W-1:0] fl_words;
  assign fl_words = fl_line;

  // Control state
  logic              rsp_ready_q;
  logic [WORD_W-1:0] rsp_data_q;
  logic              dem_pend, dem_instr;
  logic [TAG_W-1:0]  dem_tag;
  logic [WIDX_W-1:0] dem_widx;
  logic              pf_pend;
  logic [TAG_W-1:0]  pf_tag;
  logic              fl_req_q, fl_dem;
  logic [TAG_W-1:0]  fl_tag_q;
  logic [1:0]        fl_dst;

  // Buffers
  logic [NUM_BUFS-1:0] b_fill, b_vld, b_hit;
  logic [WORD_W-1:0]   b_word [NUM_BUFS];

  for (genvar gi = 0; gi < NUM_BUFS; gi++) begin : g_buf
    assign b_fill[gi] = fl_req_q && fl_ack && !fl_busy && (fl_dst == 2'(gi));
    fla_line_buf #(.TAG_W(TAG_W), .WORD_W(WORD_W), .WORDS(WORDS)) u_buf (
      .clk      (clk),
      .rst      (rst),
      .inval    (fl_busy),
      .fill_en  (b_fill[gi]),
      .fill_tag (fl_tag_q),
      .fill_line(fl_line),
      .cmp_tag  (req_tag),
      .widx     (req_widx),
      .vld      (b_vld[gi]),
      .hit      (b_hit[gi]),
      .word     (b_word[gi])
    );
  end

  logic     use_buf;
  buf_sel_e src;

  fla_policy u_policy (
    .mode    (mode),
    .is_instr(req_instr),
    .is_seq  (req_seq),
    .hit_pf  (b_hit[BUF_PF]),
    .hit_br  (b_hit[BUF_BR]),
    .hit_dt  (b_hit[BUF_DT]),
    .use_buf (use_buf),
    .src     (src)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_ready_q <= 1'b0;
      rsp_data_q  <= '0;
      dem_pend    <= 1'b0;
      dem_instr   <= 1'b0;
      dem_tag     <= '0;
      dem_widx    <= '0;
      pf_pend     <= 1'b0;
      pf_tag      <= '0;
      fl_req_q    <= 1'b0;
      fl_dem      <= 1'b0;
      fl_tag_q    <= '0;
      fl_dst      <= BUF_DT;
    end else begin
      rsp_ready_q <= 1'b0;
      if (fl_busy) begin
        // Abort any fetch in flight; a pending demand is reissued later.
        fl_req_q <= 1'b0;
      end else begin
        // Fetch completion or issue
        if (fl_req_q && fl_ack) begin
          fl_req_q <= 1'b0;
          if (fl_dem) begin
            rsp_ready_q <= 1'b1;
            rsp_data_q  <= fl_words[dem_widx];
            dem_pend    <= 1'b0;
            if (dem_instr && mode != 2'd0) begin
              pf_pend <= 1'b1;
              pf_tag  <= dem_tag + 1'b1;
            end
          end
        end else if (!fl_req_q) begin
          if (dem_pend) begin
            fl_req_q <= 1'b1;
            fl_dem   <= 1'b1;
            fl_tag_q <= dem_tag;
            fl_dst   <= dem_instr ? BUF_BR : BUF_DT;
          end else if (pf_pend) begin
            pf_pend <= 1'b0;
            if (mode != 2'd0) begin
              fl_req_q <= 1'b1;
              fl_dem   <= 1'b0;
              fl_tag_q <= pf_tag;
              fl_dst   <= BUF_PF;
            end
          end
        end
        // New request decision
        if (req_valid && !dem_pend) begin
          if (use_buf) begin
            rsp_ready_q <= 1'b1;
            rsp_data_q  <= b_word[src];
            if (req_instr && req_widx == LAST_W && mode != 2'd0) begin
              pf_pend <= 1'b1;
              pf_tag  <= req_tag + 1'b1;
            end
          end else begin
            dem_pend  <= 1'b1;
            dem_tag   <= req_tag;
            dem_widx  <= req_widx;
            dem_instr <= req_instr;
          end
        end
      end
    end
  end

  assign rsp_ready    = rsp_ready_q;
  assign rsp_data     = rsp_data_q;
  assign fl_req       = fl_req_q;
  assign fl_line_addr = fl_tag_q;

  // Assertions
  p_busy_stall_r9: assert property (@(posedge clk) disable iff (rst)
    fl_busy |=> (!rsp_ready && !fl_req));

  p_busy_inval_r10: assert property (@(posedge clk) disable iff (rst)
    fl_busy |=> (b_vld == '0));

  p_req_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (fl_req && !fl_ack && !fl_busy) |=> (fl_req && $stable(fl_line_addr)));

  p_mode0_fetch_r2: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready && $past(mode) == 2'd0) |-> $past(fl_ack));

  p_mode1_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_ready && $past(mode) == 2'd1 && !($past(req_instr) && $past(req_seq)))
      |-> $past(fl_ack));
endmodule

// File: tb/flash_line_accel_bench.sv
module flash_line_accel_bench;
  localparam int LAT = 3;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [1:0]   mode = 2'd0;
  logic         req_valid = 1'b0;
  logic [31:0]  req_addr = '0;
  logic         req_instr = 1'b0;
  logic         req_seq = 1'b0;
  logic         rsp_ready;
  logic [31:0]  rsp_data;
  logic         fl_req;
  logic [14:0]  fl_line_addr;
  logic         fl_ack = 1'b0;
  logic [127:0] fl_line = '0;
  logic         fl_busy = 1'b0;

  int total = 0;
  int bad = 0;
  int ver = 0;
  int ack_cnt = 0;
  int fcnt = 0;
  int mon_bad8 = 0;
  int mon_bad9 = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  flash_line_accel u_flash_line_accel (
    .clk(clk), .rst(rst), .mode(mode), .req_valid(req_valid),
    .req_addr(req_addr), .req_instr(req_instr), .req_seq(req_seq),
    .rsp_ready(rsp_ready), .rsp_data(rsp_data), .fl_req(fl_req),
    .fl_line_addr(fl_line_addr), .fl_ack(fl_ack), .fl_line(fl_line),
    .fl_busy(fl_busy)
  );

  function automatic logic [31:0] fword(input logic [14:0] tg, input logic [1:0] w);
    logic [31:0] k;
    k = {7'd0, ver[7:0], tg, w};
    return k * 32'h9E37_79B9 + 32'h0123_4567;
  endfunction

  function automatic logic [127:0] mk_line(input logic [14:0] tg);
    logic [127:0] l;
    for (int w = 0; w < 4; w++) l[w*32 +: 32] = fword(tg, 2'(w));
    return l;
  endfunction

  // Flash array model with fixed access latency
  always @(negedge clk) begin
    if (rst) begin
      fl_ack = 1'b0;
      fcnt = 0;
    end else if (fl_ack) begin
      fl_ack = 1'b0;
      fcnt = 0;
    end else if (fl_req && !fl_busy) begin
      if (fcnt >= LAT - 1) begin
        fl_ack = 1'b1;
        fl_line = mk_line(fl_line_addr);
        ack_cnt++;
      end else begin
        fcnt++;
      end
    end else begin
      fcnt = 0;
    end
  end

  // Port monitor for R8 and R9
  logic p_req = 1'b0, p_ack = 1'b0, p_busy = 1'b0;
  logic [14:0] p_addr = '0;
  always begin
    @(negedge clk);
    #2;
    if (!rst) begin
      if (p_busy && (fl_req || rsp_ready)) mon_bad9++;
      if (p_req && !p_ack && !p_busy && (!fl_req || fl_line_addr != p_addr)) mon_bad8++;
    end
    p_req = fl_req; p_ack = fl_ack; p_busy = fl_busy; p_addr = fl_line_addr;
  end

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic do_req(input logic [14:0] tg, input logic [1:0] w, input logic ins,
                        input logic sq, output logic [31:0] d, output int nf,
                        output int lat);
    int a0;
    a0 = ack_cnt;
    req_addr = {13'd0, tg, w, 2'b00};
    req_instr = ins;
    req_seq = sq;
    req_valid = 1'b1;
    lat = 0;
    do begin
      @(negedge clk); #1;
      lat++;
    end while (!rsp_ready && lat < 500);
    d = rsp_data;
    nf = ack_cnt - a0;
    req_valid = 1'b0;
  endtask

  task automatic idle(input int n, output int acks);
    int a0;
    a0 = ack_cnt;
    repeat (n) begin @(negedge clk); #1; end
    acks = ack_cnt - a0;
  endtask

  task automatic report();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      report();
    end
  end

  initial begin
    logic [31:0] d;
    int nf, lat, acks, seed;
    seed = $urandom(32'h00C0_FFEE);
    @(negedge clk); #1;
    check(!rsp_ready && !fl_req, "R11 during reset", {30'd0, rsp_ready, fl_req}, 0);
    repeat (4) begin @(negedge clk); #1; end
    rst = 1'b0;
    @(negedge clk); #1;
    check(!rsp_ready && !fl_req, "R11 after reset", {30'd0, rsp_ready, fl_req}, 0);

    // Mode 1 directed
    mode = 2'd1;
    do_req(15'd5, 2'd0, 1'b1, 1'b0, d, nf, lat);
    check(d == fword(15'd5, 2'd0), "R1 branch miss data", d, fword(15'd5, 2'd0));
    check(nf >= 1, "R4 mode1 branch fetches", nf, 1);
    idle(30, acks);
    check(acks == 1, "R7 next-line prefetch", acks, 1);
    do_req(15'd5, 2'd1, 1'b1, 1'b1, d, nf, lat);
    check(nf == 0 && lat == 1, "R3 mode1 seq hit branch buf", {nf[15:0], lat[15:0]}, 32'h1);
    check(d == fword(15'd5, 2'd1), "R3 seq hit data", d, fword(15'd5, 2'd1));
    do_req(15'd6, 2'd0, 1'b1, 1'b1, d, nf, lat);
    check(nf == 0 && lat == 1, "R7 seq hit prefetch buf", {nf[15:0], lat[15:0]}, 32'h1);
    check(d == fword(15'd6, 2'd0), "R7 prefetched data", d, fword(15'd6, 2'd0));
    do_req(15'd5, 2'd2, 1'b1, 1'b0, d, nf, lat);
    check(nf >= 1, "R4 mode1 buffered branch fetches", nf, 1);
    idle(30, acks);
    do_req(15'd9, 2'd0, 1'b0, 1'b0, d, nf, lat);
    check(nf >= 1 && d == fword(15'd9, 2'd0), "R4 mode1 data miss", d, fword(15'd9, 2'd0));
    do_req(15'd9, 2'd1, 1'b0, 1'b1, d, nf, lat);
    check(nf >= 1, "R4 mode1 buffered data fetches", nf, 1);

    // Mode 2 directed
    mode = 2'd2;
    do_req(15'd9, 2'd3, 1'b0, 1'b0, d, nf, lat);
    check(nf == 0 && lat == 1, "R6 data line held", {nf[15:0], lat[15:0]}, 32'h1);
    check(d == fword(15'd9, 2'd3), "R6 data hit word", d, fword(15'd9, 2'd3));
    do_req(15'd12, 2'd2, 1'b0, 1'b0, d, nf, lat);
    do_req(15'd12, 2'd0, 1'b0, 1'b0, d, nf, lat);
    check(nf == 0 && lat == 1 && d == fword(15'd12, 2'd0), "R6 other word hits", d,
          fword(15'd12, 2'd0));
    do_req(15'd5, 2'd3, 1'b1, 1'b0, d, nf, lat);
    check(nf == 0 && lat == 1 && d == fword(15'd5, 2'd3), "R5 mode2 branch hit", d,
          fword(15'd5, 2'd3));
    mode = 2'd3;
    do_req(15'd12, 2'd1, 1'b0, 1'b0, d, nf, lat);
    check(nf == 0 && lat == 1 && d == fword(15'd12, 2'd1), "R5 mode3 data hit", d,
          fword(15'd12, 2'd1));

    // Mode 0 directed
    mode = 2'd0;
    idle(30, acks);
    do_req(15'd12, 2'd0, 1'b0, 1'b0, d, nf, lat);
    check(nf >= 1 && d == fword(15'd12, 2'd0), "R2 mode0 data fetches", nf, 1);
    do_req(15'd20, 2'd0, 1'b1, 1'b0, d, nf, lat);
    idle(30, acks);
    check(acks == 0, "R2 mode0 no prefetch", acks, 0);
    do_req(15'd20, 2'd1, 1'b1, 1'b1, d, nf, lat);
    check(nf >= 1 && d == fword(15'd20, 2'd1), "R2 mode0 seq fetches", nf, 1);

    // Program/erase during a request
    mode = 2'd2;
    do_req(15'd12, 2'd0, 1'b0, 1'b0, d, nf, lat);
    fl_busy = 1'b1;
    ver++;
    fork
      begin
        repeat (12) begin @(negedge clk); #1; end
        fl_busy = 1'b0;
      end
      do_req(15'd12, 2'd1, 1'b0, 1'b0, d, nf, lat);
    join
    check(lat > 12, "R9 stalled while busy", lat, 13);
    check(nf >= 1 && d == fword(15'd12, 2'd1), "R10 fresh data after erase", d,
          fword(15'd12, 2'd1));

    // Random traffic
    for (int i = 0; i < 400; i++) begin
      logic [14:0] tg;
      logic [1:0]  w;
      logic        ins, sq;
      if (i % 50 == 0) mode = 2'($urandom % 4);
      if ($urandom % 40 == 0) begin
        fl_busy = 1'b1;
        ver++;
        repeat (5 + $urandom % 10) begin @(negedge clk); #1; end
        fl_busy = 1'b0;
      end
      tg  = 15'($urandom % 6);
      w   = 2'($urandom % 4);
      ins = 1'($urandom % 2);
      sq  = 1'($urandom % 2);
      do_req(tg, w, ins, sq, d, nf, lat);
      check(d == fword(tg, w), "R1 random data", d, fword(tg, w));
      if (mode == 2'd0) check(nf >= 1, "R2 random mode0 fetch", nf, 1);
      if (mode == 2'd1 && !(ins && sq)) check(nf >= 1, "R4 random mode1 fetch", nf, 1);
      if ($urandom % 8 == 0) idle(1 + $urandom % 10, acks);
    end

    check(mon_bad8 == 0, "R8 fetch request held stable", mon_bad8, 0);
    check(mon_bad9 == 0, "R9 quiet while busy", mon_bad9, 0);
    done = 1'b1;
    report();
  end
endmodule